// File: doc/BRIEF.md
# Digital Gain and Offset Code Calibrator

This block trims a converter input code before it reaches the converter. The host loads a gain word and a zero word through two separate write strobes and then writes data codes. On each data write the block scales the code by a factor between one half and about one and a half, adds a signed offset and clamps the sum to the legal code range. It registers the result and holds it until the next data write. When calibration is off, the data code goes straight through.

The gain word is unsigned, and the value 0x8000 stands for unity. The zero word is signed. A parameter selects either the full 16-bit code width or a 12-bit variant. In the 12-bit variant the data code sits in the upper twelve bits of the 16-bit data word. Range selection, the analog path and the register access path are outside the block. Every input arrives on plain ports.

Top module: `calib_core`

## Requirements
- R1: A synchronous active-high reset loads `code_out` from `clr_code`, drops `out_vld`, and returns the stored gain word and zero word to 0x0000. A later calibrated write therefore sees a gain of exactly one half and no offset.
- R2: On a data write with `cal_en` low, the next `code_out` equals the data code unchanged: `data_in[15:0]` for the 16-bit build, or `data_in[15:4]` for the 12-bit build.
- R3: On a data write with `cal_en` high, the scaled term is floor(code × (gain + 32768) / 65536), where gain is the stored unsigned gain word. A gain word of 0x8000 is unity and 0x0000 is one half.
- R4: The stored zero word is read as a two's-complement number and added to the scaled term. For the 12-bit build the zero word is arithmetically shifted right by 4 before the addition.
- R5: A corrected sum above the maximum code yields the maximum code: 0xFFFF for 16 bits, 0xFFF for 12 bits.
- R6: A corrected sum below zero yields code 0.
- R7: Loading a new gain word (`gain_wr`) or zero word (`zero_wr`) from `coef_word` leaves `code_out` unchanged. The new word affects only the next data write.
- R8: `code_out` and `out_vld` change one clock after `wr_stb`. `out_vld` is high for exactly that one cycle, and `code_out` holds its value in every cycle that follows no data write.
- R9: For the 12-bit build, bits 3:0 of `data_in` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Data write strobe, one cycle |
| data_in | input | 16 | Data word; the code occupies the top DW bits |
| cal_en | input | 1 | Calibration enable, sampled with `wr_stb` |
| gain_wr | input | 1 | Load `coef_word` into the gain register |
| zero_wr | input | 1 | Load `coef_word` into the zero register |
| coef_word | input | 16 | Gain (unsigned) or zero (two's complement) word |
| clr_code | input | DW | Code loaded into `code_out` on reset |
| code_out | output | DW | Corrected, saturated code |
| out_vld | output | 1 | One-cycle pulse when `code_out` is updated |

## Verification
The hardest situations to reach are the two saturation regions, together with ruling out any leak of coefficient writes into a held output. The stimulus drives a 16-bit and a 12-bit instance from the same inputs. It sweeps 4096 data codes, whose low nibble varies, through a set of corner coefficients. These include the largest gain with the largest positive zero and the smallest gain with the most negative zero, so both clamp regions and the exact unity case are hit many times. Between data writes it reloads coefficients and checks that the held code does not move until the next strobe.

// File: rtl/calib_pkg.sv
package calib_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned GAIN_EXTW = WORD_W + 1;
  localparam logic [GAIN_EXTW-1:0] GAIN_BIAS = GAIN_EXTW'(1) << (WORD_W - 1);
endpackage

// File: rtl/calib_coef_regs.sv
module calib_coef_regs
  import calib_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gain_wr,
  input  logic              zero_wr,
  input  logic [WORD_W-1:0] coef_word,
  output logic [WORD_W-1:0] gain_q,
  output logic [WORD_W-1:0] zero_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      zero_q <= '0;
    end else begin
      if (gain_wr) gain_q <= coef_word;
      if (zero_wr) zero_q <= coef_word;
    end
  end

  // R1
  coef_reset_chk: assert property (@(posedge clk) rst |=> (gain_q == '0 && zero_q == '0));
endmodule

// File: rtl/calib_scale.sv
module calib_scale
  import calib_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]     code,
  input  logic [WORD_W-1:0] gain,
  output logic [DW:0]       scaled
);
  localparam int unsigned PW = DW + GAIN_EXTW;

  logic [GAIN_EXTW-1:0] gain_eff;
  logic [PW-1:0]        prod;

  assign gain_eff = {1'b0, gain} + GAIN_BIAS;
  assign prod     = PW'(code) * PW'(gain_eff);
  assign scaled   = prod[PW-1:WORD_W];
endmodule

// File: rtl/calib_offset_sat.sv
module calib_offset_sat #(
  parameter int unsigned DW = 16
) (
  input  logic [DW:0]   scaled,
  input  logic [DW-1:0] zero,
  output logic [DW-1:0] res
);
  localparam int unsigned SW = DW + 2;

  logic signed [SW-1:0] sum;

  assign sum = $signed({1'b0, scaled}) + $signed({{2{zero[DW-1]}}, zero});

  always_comb begin
    if (sum[SW-1])
      res = '0;
    else if (sum[SW-2:DW] != '0)
      res = '1;
    else
      res = sum[DW-1:0];
  end
endmodule

// File: rtl/calib_core.sv
module calib_core
  import calib_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] data_in,
  input  logic              cal_en,
  input  logic              gain_wr,
  input  logic              zero_wr,
  input  logic [WORD_W-1:0] coef_word,
  input  logic [DW-1:0]     clr_code,
  output logic [DW-1:0]     code_out,
  output logic              out_vld
);
  localparam int unsigned SHIFT = WORD_W - DW;

  logic [WORD_W-1:0] gain_q;
  logic [WORD_W-1:0] zero_q;
  logic [DW-1:0]     code;
  logic [DW-1:0]     zero_n;
  logic [DW:0]       scaled;
  logic [DW-1:0]     corrected;

  calib_coef_regs u_coef (
    .clk(clk), .rst(rst), .gain_wr(gain_wr), .zero_wr(zero_wr),
    .coef_word(coef_word), .gain_q(gain_q), .zero_q(zero_q)
  );

  // Top DW bits of a 16-bit word: arithmetic shift for the signed zero word.
  assign code   = data_in[WORD_W-1:SHIFT];
  assign zero_n = zero_q[WORD_W-1:SHIFT];

  generate
    if (SHIFT > 0) begin : g_narrow
      logic unused_low;
      assign unused_low = ^{data_in[SHIFT-1:0], zero_q[SHIFT-1:0]};
    end
  endgenerate

  calib_scale #(.DW(DW)) u_scale (
    .code(code), .gain(gain_q), .scaled(scaled)
  );

  calib_offset_sat #(.DW(DW)) u_sat (
    .scaled(scaled), .zero(zero_n), .res(corrected)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= clr_code;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= wr_stb;
      if (wr_stb) code_out <= cal_en ? corrected : code;
    end
  end

  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst) wr_stb |=> out_vld);
  // R8
  vld_single_chk: assert property (@(posedge clk) disable iff (rst) !wr_stb |=> !out_vld);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst) !wr_stb |=> $stable(code_out));
  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !cal_en) |=> code_out == $past(data_in[WORD_W-1:SHIFT]));
  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && cal_en && gain_q == '0 && zero_q == 16'h8000) |=> code_out == '0);
endmodule

// File: tb/sim_calib_core.sv
module sim_calib_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_stb = 0;
  logic [15:0] data_in = 0;
  logic        cal_en = 0;
  logic        gain_wr = 0;
  logic        zero_wr = 0;
  logic [15:0] coef_word = 0;
  logic [15:0] code16;
  logic [11:0] code12;
  logic        vld16, vld12;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] m_gain = 0;
  logic [15:0] m_zero = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calib_core #(.DW(16)) u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .data_in(data_in), .cal_en(cal_en),
    .gain_wr(gain_wr), .zero_wr(zero_wr), .coef_word(coef_word),
    .clr_code(16'hABCD), .code_out(code16), .out_vld(vld16)
  );

  calib_core #(.DW(12)) u1 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .data_in(data_in), .cal_en(cal_en),
    .gain_wr(gain_wr), .zero_wr(zero_wr), .coef_word(coef_word),
    .clr_code(12'h5A3), .code_out(code12), .out_vld(vld12)
  );

  function automatic longint expect_code(logic [15:0] d, logic [15:0] g,
                                         logic [15:0] z, logic en, int dw);
    int sh = 16 - dw;
    longint c = longint'(d >> sh);
    longint zs = longint'($signed(z)) >>> sh;
    longint mx = (longint'(1) << dw) - 1;
    longint s;
    if (!en) return c;
    s = ((c * (longint'(g) + 32768)) >> 16) + zs;
    if (s < 0) s = 0;
    if (s > mx) s = mx;
    return s;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_gain(logic [15:0] w);
    @(negedge clk); coef_word = w; gain_wr = 1;
    @(negedge clk); gain_wr = 0;
    m_gain = w;
  endtask

  task automatic set_zero(logic [15:0] w);
    @(negedge clk); coef_word = w; zero_wr = 1;
    @(negedge clk); zero_wr = 0;
    m_zero = w;
  endtask

  task automatic write_data(logic [15:0] d, logic en, string req);
    @(negedge clk); data_in = d; cal_en = en; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    check(req, code16, expect_code(d, m_gain, m_zero, en, 16));
    check(req, code12, expect_code(d, m_gain, m_zero, en, 12));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_gain = 0; m_zero = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] gains [6];
    logic [15:0] zeros [6];
    logic [15:0] held16;
    logic [11:0] held12;
    gains = '{16'h0000, 16'h8000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h1234};
    zeros = '{16'h0000, 16'h0000, 16'h0000, 16'h7FFF, 16'h8000, 16'hFF00};

    repeat (2) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1", code16, 16'hABCD);
    check("R1", code12, 12'h5A3);
    check("R1", vld16, 0);
    // R1 reset coefficients: gain 0.5, no offset
    write_data(16'hF00F, 1, "R1");

    // R2 bypass sweep, R9 low nibble varies
    for (int i = 0; i < 4096; i += 7) write_data(16'(i * 16 + (i % 16)), 0, "R2");

    // R3..R6, R9 sweeps over corner coefficient sets
    for (int k = 0; k < 6; k++) begin
      set_gain(gains[k]);
      set_zero(zeros[k]);
      for (int i = 0; i < 4096; i++) write_data(16'(i * 16 + (i % 16)), 1, "R3/R4/R5/R6/R9");
      write_data(16'hFFFF, 1, "R5");
    end

    // R5 explicit: max gain, max positive zero, full-scale code
    set_gain(16'hFFFF); set_zero(16'h7FFF);
    write_data(16'hFFFF, 1, "R5");
    check("R5", code16, 16'hFFFF);
    // R6 explicit: half gain, most negative zero
    set_gain(16'h0000); set_zero(16'h8000);
    write_data(16'hFFFF, 1, "R6");
    check("R6", code16, 16'h0000);
    // R3 explicit unity
    set_gain(16'h8000); set_zero(16'h0000);
    write_data(16'h1234, 1, "R3");
    check("R3", code16, 16'h1234);
    // R9: low nibble ignored in 12-bit build
    write_data(16'h1230, 1, "R9");
    held12 = code12;
    write_data(16'h123F, 1, "R9");
    check("R9", code12, held12);

    // R7 coefficient writes leave held output alone
    held16 = code16; held12 = code12;
    set_gain(16'h0000);
    set_zero(16'h0100);
    check("R7", code16, held16);
    check("R7", code12, held12);
    write_data(16'h1234, 1, "R7");
    check("R7", code16, 16'h091A + 16'h0100);

    // R8 valid pulse and hold
    @(negedge clk); data_in = 16'h4000; cal_en = 0; wr_stb = 1;
    check("R8", vld16, 0);
    @(negedge clk); wr_stb = 0;
    check("R8", vld16, 1);
    check("R8", vld12, 1);
    held16 = code16;
    data_in = 16'hFFFF; cal_en = 1;
    repeat (3) @(negedge clk);
    check("R8", vld16, 0);
    check("R8", code16, held16);

    // R1 reset mid-run restores coefficients and clear code
    set_gain(16'hFFFF); set_zero(16'h0500);
    do_reset();
    check("R1", code16, 16'hABCD);
    check("R1", code12, 12'h5A3);
    write_data(16'h8000, 1, "R1");
    check("R1", code16, 16'h4000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule